// File: doc/BRIEF.md
# Parallel sample packing buffer

This block sits in front of a bank of filter channels and supplies each channel with 16-bit samples. A channel takes its samples either from the result bus of an on-chip converter or from a 32-bit data register that software or a memory-copy engine fills through a write port. A write can carry 16 or 32 bits, as set by its byte enables. So one write loads one sample or two.

A 2-bit packing mode sets how the register drains toward the filter:
- **Standard:** one sample per write. Only the low half-word counts.
- **Pair:** two consecutive samples per write, the low half-word first.
- **Split:** the low half-word goes to this channel. The high half-word is forwarded into the low half-word of the next channel up.

The filter side takes samples with a valid/acknowledge handshake. Each sample carries a flag that marks which half of the register it came from. The forwarded half-word of the highest channel leaves the block on a copy strobe, so a further bank can be chained to it.

Top module: `pkbuf_top`

## Requirements
- R1: With a channel's source select at any value other than 2, the channel's sample valid, data and half flag follow the converter inputs directly: valid equals the converter valid, data equals the converter data, and the half flag is 0. The packing mode has no effect, and bus writes to that channel do not appear on its sample output.
- R2: With source select 2 and packing mode 0 (standard), a write whose byte enables touch the low half-word (bits 15:0) yields exactly one sample equal to the low half-word. Bytes written in the upper half are ignored.
- R3: Packing mode 3 behaves exactly as standard mode.
- R4: In packing mode 1 (pair), a 32-bit write yields two samples in order: first the low half-word with half flag 0, then the high half-word (bits 31:16) with half flag 1.
- R5: In pair mode, a write touching only the low half-word yields one sample only.
- R6: In packing mode 2 (split), a write yields the low half-word as a sample of its own channel. When the upper bytes are enabled, the high half-word is forwarded one clock later into channel y+1, which then presents it as a low-half sample.
- R7: A split-mode write with upper bytes enabled to the highest channel raises the copy strobe output for one cycle, in the cycle after the write, with the high half-word on the copy data output.
- R8: Sample valid stays asserted while pending samples remain. Each acknowledge removes one pending sample. An acknowledge with nothing pending has no effect.
- R9: A write that arrives while samples are pending replaces them and sets a sticky overrun flag. The flag clears only when a one is applied to the channel's overrun-clear input.
- R10: After reset no sample is valid, all overrun flags are 0 and the copy strobe is 0.
- R11: Byte enables act per byte. A write with only byte 0 enabled replaces bits 7:0 of the low half-word and keeps bits 15:8 from the previous write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the data registers |
| wr_ch | input | CH_W | Channel addressed by the write |
| wr_be | input | 2*HW/8 | Byte enables; the low HW/8 bits cover the low half-word |
| wr_data | input | 2*HW | Write data; low half in bits HW-1:0 |
| ovr_clr | input | NUM_CH | Per-channel overrun clear, write-one-to-clear |
| src_sel | input | 2*NUM_CH | Per-channel source select; 2 picks the data register |
| pack_mode | input | 2*NUM_CH | Per-channel packing mode: 0 standard, 1 pair, 2 split, 3 as 0 |
| adc_data | input | HW*NUM_CH | Converter result per channel |
| adc_valid | input | NUM_CH | Converter result valid per channel |
| smp_ack | input | NUM_CH | Filter takes the presented sample |
| smp_valid | output | NUM_CH | A sample is presented |
| smp_data | output | HW*NUM_CH | Presented sample per channel |
| smp_hi | output | NUM_CH | Presented sample came from the high half-word |
| ovr_flag | output | NUM_CH | Sticky overrun flag per channel |
| xcp_stb | output | 1 | Forwarded half-word strobe from the highest channel |
| xcp_data | output | HW | Forwarded half-word from the highest channel |

## Verification
The hardest situation to reach is a forwarded half-word landing in a neighbouring channel. That half-word must appear one cycle after the originating channel's own sample and must keep its place in the order of all channels' results. The bench writes a split-mode word to a middle channel while a free-running monitor acknowledges every valid sample. The scoreboard queue then demands the originating low half first and the neighbour's copy second. Overrun is reached by switching the monitor off so that a second write finds a pending sample.

// File: rtl/pkbuf_pkg.sv
// Package: shared types and decode helpers for the sample packing buffer.
// Assumes two-bit packing and source fields per channel.
package pkbuf_pkg;

    typedef enum logic [1:0] {
        PK_STD   = 2'd0,
        PK_PAIR  = 2'd1,
        PK_SPLIT = 2'd2,
        PK_RSVD  = 2'd3
    } pack_e;

    localparam logic [1:0] SRC_BUS = 2'd2;

    // Per-write command produced by the decoder and applied by the lane.
    typedef struct packed {
        logic       load;
        logic [1:0] cnt;
        logic       rd_hi;
        logic       fwd;
        logic       collide;
    } wr_cmd_t;

    // Map the reserved packing code onto standard mode.
    function automatic pack_e pack_eff(input logic [1:0] m);
        if (m == 2'd3) return PK_STD;
        return pack_e'(m);
    endfunction

endpackage

// File: rtl/pkbuf_wrdec.sv
// Module: per-channel write decoder. Turns a bus write or a forwarded
// half-word from the channel below into byte masks, data and a fill count.
// Assumes HW is a multiple of 8; a bus write wins over a forwarded copy
// arriving in the same cycle, and that collision is reported.
module pkbuf_wrdec
    import pkbuf_pkg::*;
#(
    parameter int CH_IDX = 0,
    parameter int HW     = 16,
    parameter int CH_W   = 2,
    localparam int NB    = HW / 8
) (
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [2*NB-1:0]   wr_be,
    input  logic [2*HW-1:0]   wr_data,
    input  logic [1:0]        mode,
    input  logic              cp_stb_i,
    input  logic [HW-1:0]     cp_data_i,
    output wr_cmd_t           cmd,
    output logic [NB-1:0]     lo_mask,
    output logic [NB-1:0]     hi_mask,
    output logic [HW-1:0]     lo_data,
    output logic [HW-1:0]     hi_data
);

    logic  bus_hit;
    logic  lo_any;
    logic  hi_any;
    pack_e m;

    // Qualify the bus write for this channel and summarise its byte lanes.
    always_comb begin
        bus_hit = wr_en && (wr_ch == CH_W'(CH_IDX));
        lo_any  = |wr_be[NB-1:0];
        hi_any  = |wr_be[2*NB-1:NB];
        m       = pack_eff(mode);
    end

    // Build the command for the lane from the active write source.
    always_comb begin
        cmd     = '0;
        lo_mask = '0;
        hi_mask = '0;
        lo_data = wr_data[HW-1:0];
        hi_data = wr_data[2*HW-1:HW];
        if (bus_hit) begin
            lo_mask     = wr_be[NB-1:0];
            cmd.collide = cp_stb_i;
            unique case (m)
                PK_PAIR: begin
                    hi_mask   = wr_be[2*NB-1:NB];
                    cmd.cnt   = {1'b0, lo_any} + {1'b0, hi_any};
                    cmd.rd_hi = !lo_any;
                end
                PK_SPLIT: begin
                    cmd.cnt = {1'b0, lo_any};
                    cmd.fwd = hi_any;
                end
                default: begin
                    cmd.cnt = {1'b0, lo_any};
                end
            endcase
        end else if (cp_stb_i) begin
            lo_mask = '1;
            lo_data = cp_data_i;
            cmd.cnt = 2'd1;
        end
        cmd.load = (cmd.cnt != 2'd0);
    end

endmodule

// File: rtl/pkbuf_lane.sv
// Module: storage for one channel. Holds both half-words, the pending
// count, the read pointer, the sticky overrun flag and the forwarding stage.
// Assumes acknowledges arrive already gated to the bus source.
module pkbuf_lane
    import pkbuf_pkg::*;
#(
    parameter int HW  = 16,
    localparam int NB = HW / 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  wr_cmd_t        cmd,
    input  logic [NB-1:0]  lo_mask,
    input  logic [NB-1:0]  hi_mask,
    input  logic [HW-1:0]  lo_data,
    input  logic [HW-1:0]  hi_data,
    input  logic           ack_i,
    input  logic           clr_i,
    output logic           valid_o,
    output logic [HW-1:0]  data_o,
    output logic           hi_o,
    output logic           ovr_o,
    output logic           cp_stb_o,
    output logic [HW-1:0]  cp_data_o
);

    logic [HW-1:0] lo_q;
    logic [HW-1:0] hi_q;
    logic [1:0]    cnt_q;
    logic          rd_hi_q;
    logic          ovr_q;
    logic          cp_stb_q;
    logic [HW-1:0] cp_data_q;
    logic          take;

    assign take = ack_i && (cnt_q != 2'd0);

    // Merge written bytes into the two half-word registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            for (int b = 0; b < NB; b++) begin
                if (lo_mask[b]) lo_q[b*8 +: 8] <= lo_data[b*8 +: 8];
                if (hi_mask[b]) hi_q[b*8 +: 8] <= hi_data[b*8 +: 8];
            end
        end
    end

    // Track pending samples and which half is presented next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= 2'd0;
            rd_hi_q <= 1'b0;
        end else if (cmd.load) begin
            cnt_q   <= cmd.cnt;
            rd_hi_q <= cmd.rd_hi;
        end else if (take) begin
            cnt_q   <= cnt_q - 2'd1;
            if (cnt_q == 2'd2) rd_hi_q <= 1'b1;
        end
    end

    // Sticky overrun: set on overwrite or lost copy, cleared by a one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else if ((cmd.load && cnt_q != 2'd0) || cmd.collide) begin
            ovr_q <= 1'b1;
        end else if (clr_i) begin
            ovr_q <= 1'b0;
        end
    end

    // One-cycle forwarding stage for the split-mode upper half-word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cp_stb_q  <= 1'b0;
            cp_data_q <= '0;
        end else begin
            cp_stb_q <= cmd.fwd;
            if (cmd.fwd) cp_data_q <= hi_data;
        end
    end

    assign valid_o   = (cnt_q != 2'd0);
    assign data_o    = rd_hi_q ? hi_q : lo_q;
    assign hi_o      = rd_hi_q;
    assign ovr_o     = ovr_q;
    assign cp_stb_o  = cp_stb_q;
    assign cp_data_o = cp_data_q;

endmodule

// File: rtl/pkbuf_srcsel.sv
// Module: per-channel source selector. Presents either the buffered sample
// or the converter result, and routes the acknowledge only to the buffer
// when the buffer is the source. Assumes converter data needs no packing.
module pkbuf_srcsel
    import pkbuf_pkg::*;
#(
    parameter int HW = 16
) (
    input  logic [1:0]     src,
    input  logic           buf_valid,
    input  logic [HW-1:0]  buf_data,
    input  logic           buf_hi,
    input  logic           adc_valid,
    input  logic [HW-1:0]  adc_data,
    input  logic           ack,
    output logic           smp_valid,
    output logic [HW-1:0]  smp_data,
    output logic           smp_hi,
    output logic           lane_ack
);

    logic bus_sel;

    // Choose the sample source and gate the acknowledge.
    always_comb begin
        bus_sel   = (src == SRC_BUS);
        smp_valid = bus_sel ? buf_valid : adc_valid;
        smp_data  = bus_sel ? buf_data  : adc_data;
        smp_hi    = bus_sel && buf_hi;
        lane_ack  = bus_sel && ack && buf_valid;
    end

endmodule

// File: rtl/pkbuf_top.sv
// Module: bank of NUM_CH sample packing channels. Each channel has a
// decoder, a lane and a source selector; split-mode copies chain from
// channel i to i+1, and the last channel's copy leaves on xcp_*.
// Assumes NUM_CH >= 2 and HW a multiple of 8.
module pkbuf_top
    import pkbuf_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int HW     = 16,
    localparam int NB    = HW / 8,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [CH_W-1:0]      wr_ch,
    input  logic [2*NB-1:0]      wr_be,
    input  logic [2*HW-1:0]      wr_data,
    input  logic [NUM_CH-1:0]    ovr_clr,
    input  logic [2*NUM_CH-1:0]  src_sel,
    input  logic [2*NUM_CH-1:0]  pack_mode,
    input  logic [HW*NUM_CH-1:0] adc_data,
    input  logic [NUM_CH-1:0]    adc_valid,
    input  logic [NUM_CH-1:0]    smp_ack,
    output logic [NUM_CH-1:0]    smp_valid,
    output logic [HW*NUM_CH-1:0] smp_data,
    output logic [NUM_CH-1:0]    smp_hi,
    output logic [NUM_CH-1:0]    ovr_flag,
    output logic                 xcp_stb,
    output logic [HW-1:0]        xcp_data
);

    logic          cp_stb_w  [NUM_CH+1];
    logic [HW-1:0] cp_data_w [NUM_CH+1];

    assign cp_stb_w[0]  = 1'b0;
    assign cp_data_w[0] = '0;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        wr_cmd_t       cmd;
        logic [NB-1:0] lo_mask;
        logic [NB-1:0] hi_mask;
        logic [HW-1:0] lo_data;
        logic [HW-1:0] hi_data;
        logic          buf_valid;
        logic [HW-1:0] buf_data;
        logic          buf_hi;
        logic          lane_ack;

        pkbuf_wrdec #(.CH_IDX(i), .HW(HW), .CH_W(CH_W)) u_dec (
            .wr_en     (wr_en),
            .wr_ch     (wr_ch),
            .wr_be     (wr_be),
            .wr_data   (wr_data),
            .mode      (pack_mode[2*i +: 2]),
            .cp_stb_i  (cp_stb_w[i]),
            .cp_data_i (cp_data_w[i]),
            .cmd       (cmd),
            .lo_mask   (lo_mask),
            .hi_mask   (hi_mask),
            .lo_data   (lo_data),
            .hi_data   (hi_data)
        );

        pkbuf_lane #(.HW(HW)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmd       (cmd),
            .lo_mask   (lo_mask),
            .hi_mask   (hi_mask),
            .lo_data   (lo_data),
            .hi_data   (hi_data),
            .ack_i     (lane_ack),
            .clr_i     (ovr_clr[i]),
            .valid_o   (buf_valid),
            .data_o    (buf_data),
            .hi_o      (buf_hi),
            .ovr_o     (ovr_flag[i]),
            .cp_stb_o  (cp_stb_w[i+1]),
            .cp_data_o (cp_data_w[i+1])
        );

        pkbuf_srcsel #(.HW(HW)) u_sel (
            .src       (src_sel[2*i +: 2]),
            .buf_valid (buf_valid),
            .buf_data  (buf_data),
            .buf_hi    (buf_hi),
            .adc_valid (adc_valid[i]),
            .adc_data  (adc_data[HW*i +: HW]),
            .ack       (smp_ack[i]),
            .smp_valid (smp_valid[i]),
            .smp_data  (smp_data[HW*i +: HW]),
            .smp_hi    (smp_hi[i]),
            .lane_ack  (lane_ack)
        );
    end

    assign xcp_stb  = cp_stb_w[NUM_CH];
    assign xcp_data = cp_data_w[NUM_CH];

endmodule

// File: rtl/pkbuf_chk.sv
// Module: assertion checker for pkbuf_top, attached by bind below.
// Assumes only the top module's ports are visible.
module pkbuf_chk #(
    parameter int NUM_CH = 4,
    parameter int HW     = 16,
    localparam int NB    = HW / 8,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [CH_W-1:0]      wr_ch,
    input logic [2*NB-1:0]      wr_be,
    input logic [NUM_CH-1:0]    ovr_clr,
    input logic [2*NUM_CH-1:0]  src_sel,
    input logic [2*NUM_CH-1:0]  pack_mode,
    input logic [HW*NUM_CH-1:0] adc_data,
    input logic [NUM_CH-1:0]    adc_valid,
    input logic [NUM_CH-1:0]    smp_ack,
    input logic [NUM_CH-1:0]    smp_valid,
    input logic [HW*NUM_CH-1:0] smp_data,
    input logic [NUM_CH-1:0]    smp_hi,
    input logic [NUM_CH-1:0]    ovr_flag,
    input logic                 xcp_stb
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_a
        // R1: converter source passes straight through
        a_r1_adc_pass: assert property (@(posedge clk) disable iff (!rst_n)
            (src_sel[2*i +: 2] != 2'd2) |->
                (smp_valid[i] == adc_valid[i] && !smp_hi[i] &&
                 smp_data[HW*i +: HW] == adc_data[HW*i +: HW]));

        // R9: overrun flag only falls after a clear request
        a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ovr_flag[i]) |-> $past(ovr_clr[i]));
    end

    // R8: taking the high-half sample of channel 0 empties it
    a_r8_hi_ack_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel[1:0] == 2'd2 && smp_valid[0] && smp_hi[0] && smp_ack[0] &&
         !(wr_en && wr_ch == CH_W'(0)))
        |=> (src_sel[1:0] != 2'd2 || !smp_valid[0]));

    // R7: copy strobe follows a split write with upper bytes to the last channel
    a_r7_copy_origin: assert property (@(posedge clk) disable iff (!rst_n)
        xcp_stb |-> $past(wr_en && wr_ch == CH_W'(NUM_CH-1) &&
                          (|wr_be[2*NB-1:NB]) &&
                          pack_mode[2*(NUM_CH-1) +: 2] == 2'd2));

endmodule

bind pkbuf_top pkbuf_chk #(.NUM_CH(NUM_CH), .HW(HW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_ch     (wr_ch),
    .wr_be     (wr_be),
    .ovr_clr   (ovr_clr),
    .src_sel   (src_sel),
    .pack_mode (pack_mode),
    .adc_data  (adc_data),
    .adc_valid (adc_valid),
    .smp_ack   (smp_ack),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .smp_hi    (smp_hi),
    .ovr_flag  (ovr_flag),
    .xcp_stb   (xcp_stb)
);

// File: tb/tb_pkbuf_top.sv
// Scoreboard bench for pkbuf_top: tasks queue expected samples, a negedge
// monitor acknowledges and compares every valid sample in channel order.
module tb_pkbuf_top;

    localparam int NCH = 4;
    localparam int HW  = 16;
    localparam int CW  = 2;

    typedef struct {
        int          ch;
        logic        hi;
        logic [15:0] d;
        string       tag;
    } exp_t;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 wr_en = 1'b0;
    logic [CW-1:0]        wr_ch = '0;
    logic [3:0]           wr_be = '0;
    logic [31:0]          wr_data = '0;
    logic [NCH-1:0]       ovr_clr = '0;
    logic [2*NCH-1:0]     src_sel = {NCH{2'd2}};
    logic [2*NCH-1:0]     pack_mode = '0;
    logic [HW*NCH-1:0]    adc_data = '0;
    logic [NCH-1:0]       adc_valid = '0;
    logic [NCH-1:0]       mon_ack = '0;
    logic [NCH-1:0]       man_ack = '0;
    logic [NCH-1:0]       smp_ack;
    logic [NCH-1:0]       smp_valid;
    logic [HW*NCH-1:0]    smp_data;
    logic [NCH-1:0]       smp_hi;
    logic [NCH-1:0]       ovr_flag;
    logic                 xcp_stb;
    logic [HW-1:0]        xcp_data;

    int   errs = 0;
    int   checks = 0;
    bit   auto_ack = 1'b1;
    bit   done = 1'b0;
    exp_t sb[$];

    assign smp_ack = mon_ack | man_ack;

    always #5 clk = ~clk;

    pkbuf_top #(.NUM_CH(NCH), .HW(HW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_be(wr_be),
        .wr_data(wr_data), .ovr_clr(ovr_clr), .src_sel(src_sel),
        .pack_mode(pack_mode), .adc_data(adc_data), .adc_valid(adc_valid),
        .smp_ack(smp_ack), .smp_valid(smp_valid), .smp_data(smp_data),
        .smp_hi(smp_hi), .ovr_flag(ovr_flag), .xcp_stb(xcp_stb),
        .xcp_data(xcp_data)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_smp(input int ch, input logic hi, input logic [15:0] d, input string tag);
        exp_t e;
        e.ch = ch; e.hi = hi; e.d = d; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic bus_wr(input int ch, input logic [3:0] be, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_ch = CW'(ch); wr_be = be; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0; wr_be = '0;
    endtask

    task automatic settle(input string tag);
        repeat (8) @(posedge clk);
        check(sb.size() == 0, {tag, " samples still missing"}, sb.size(), 0);
    endtask

    // Monitor: acknowledge and compare each presented sample.
    always @(negedge clk) begin
        exp_t e;
        mon_ack = '0;
        if (rst_n && auto_ack) begin
            for (int c = 0; c < NCH; c++) begin
                if (smp_valid[c]) begin
                    checks++;
                    if (sb.size() == 0) begin
                        errs++;
                        $display("FAIL R1/R2 ch%0d unexpected sample actual=%0h expected=none",
                                 c, smp_data[HW*c +: HW]);
                    end else begin
                        e = sb.pop_front();
                        if (e.ch != c || e.d != smp_data[HW*c +: HW] || e.hi != smp_hi[c]) begin
                            errs++;
                            $display("FAIL %s actual=ch%0d/%0h/hi%0b expected=ch%0d/%0h/hi%0b",
                                     e.tag, c, smp_data[HW*c +: HW], smp_hi[c], e.ch, e.d, e.hi);
                        end
                    end
                    mon_ack[c] = 1'b1;
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(smp_valid == '0, "R10 valid after reset", smp_valid, 0);
        check(ovr_flag == '0, "R10 overrun after reset", ovr_flag, 0);
        check(xcp_stb == 1'b0, "R10 copy strobe after reset", xcp_stb, 0);

        // R2: standard mode keeps the low half only
        expect_smp(0, 1'b0, 16'h5678, "R2 standard low half");
        bus_wr(0, 4'hF, 32'h1234_5678);
        settle("R2");

        // R11: byte-lane merge
        expect_smp(0, 1'b0, 16'hAAAA, "R11 full low half");
        bus_wr(0, 4'h3, 32'h0000_AAAA);
        settle("R11 first");
        expect_smp(0, 1'b0, 16'hAA55, "R11 byte 0 merged");
        bus_wr(0, 4'h1, 32'hFFFF_FF55);
        settle("R11");

        // R3: reserved mode acts as standard
        pack_mode[7:6] = 2'd3;
        expect_smp(3, 1'b0, 16'h1111, "R3 reserved as standard");
        bus_wr(3, 4'hF, 32'h9999_1111);
        settle("R3");

        // R4: pair mode, low then high
        pack_mode[5:4] = 2'd1;
        expect_smp(2, 1'b0, 16'hC0D0, "R4 pair first low");
        expect_smp(2, 1'b1, 16'hA0B0, "R4 pair second high");
        bus_wr(2, 4'hF, 32'hA0B0_C0D0);
        settle("R4");

        // R5: pair mode with a 16-bit write
        expect_smp(2, 1'b0, 16'h0101, "R5 pair single sample");
        bus_wr(2, 4'h3, 32'hFFFF_0101);
        settle("R5");

        // R6: split mode forwards to the next channel
        pack_mode[3:2] = 2'd2;
        expect_smp(1, 1'b0, 16'hCAFE, "R6 split own low");
        expect_smp(2, 1'b0, 16'hBEEF, "R6 split forwarded to y+1");
        bus_wr(1, 4'hF, 32'hBEEF_CAFE);
        settle("R6");

        // R7: last channel drives the copy outputs for one cycle
        pack_mode[7:6] = 2'd2;
        expect_smp(3, 1'b0, 16'h3333, "R7 split own low");
        bus_wr(3, 4'hF, 32'h7777_3333);
        @(negedge clk);
        check(xcp_stb == 1'b1, "R7 copy strobe high", xcp_stb, 1);
        check(xcp_data == 16'h7777, "R7 copy data", xcp_data, 16'h7777);
        @(negedge clk);
        check(xcp_stb == 1'b0, "R7 copy strobe one cycle", xcp_stb, 0);
        settle("R7");

        // R9 and R8: overwrite, hold, acknowledge, clear
        auto_ack = 1'b0;
        bus_wr(0, 4'h3, 32'h0000_1111);
        bus_wr(0, 4'h3, 32'h0000_2222);
        @(negedge clk);
        check(ovr_flag[0] == 1'b1, "R9 overrun set", ovr_flag[0], 1);
        check(smp_data[15:0] == 16'h2222, "R9 newer data kept", smp_data[15:0], 16'h2222);
        repeat (3) @(negedge clk);
        check(smp_valid[0] == 1'b1, "R8 valid held while pending", smp_valid[0], 1);
        @(posedge clk); #1 man_ack[0] = 1'b1;
        @(posedge clk); #1 man_ack[0] = 1'b0;
        @(negedge clk);
        check(smp_valid[0] == 1'b0, "R8 ack drains sample", smp_valid[0], 0);
        @(posedge clk); #1 man_ack[0] = 1'b1;
        @(posedge clk); #1 man_ack[0] = 1'b0;
        @(negedge clk);
        check(smp_valid[0] == 1'b0, "R8 empty ack no effect", smp_valid[0], 0);
        check(ovr_flag[0] == 1'b1, "R9 overrun sticky", ovr_flag[0], 1);
        @(posedge clk); #1 ovr_clr[0] = 1'b1;
        @(posedge clk); #1 ovr_clr[0] = 1'b0;
        @(negedge clk);
        check(ovr_flag[0] == 1'b0, "R9 overrun cleared", ovr_flag[0], 0);
        auto_ack = 1'b1;

        // R1: converter source passes through, packing and bus ignored
        src_sel[3:2] = 2'd0;
        pack_mode[3:2] = 2'd1;
        expect_smp(1, 1'b0, 16'h4242, "R1 converter sample");
        @(posedge clk); #1;
        adc_data[31:16] = 16'h4242; adc_valid[1] = 1'b1;
        @(posedge clk); #1;
        adc_valid[1] = 1'b0;
        settle("R1 converter");
        bus_wr(1, 4'hF, 32'h5555_6666);
        settle("R1 bus ignored");
        @(negedge clk);
        check(smp_valid[1] == 1'b0, "R1 bus data not presented", smp_valid[1], 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule